// File: doc/BRIEF.md
# Hint-Steered L0 Buffer Fill and Lookup Unit

This unit sits between a shared first-level data cache and a set of small buffers, one buffer per execution cluster. Cache blocks returning from the first level arrive as four 32-bit words. Each block is written into the buffers in one of two ways, chosen by a hint that travels with the access. In linear mode the whole block goes into the buffer of the cluster that asked for it. In scatter mode the block is split up, and each word goes to the buffer of the cluster whose index equals the word's position. Scatter mode suits loops that step through an array four elements at a time. It takes one cycle longer than linear mode.

Loads from a cluster look up that cluster's buffer and get an answer one cycle later. On a miss, or when the bypass hint is set, the unit issues a read to the first level. A non-bypass load may also request a prefetch of the block just after or just before its own block. Stores always go straight through to the first level. Every buffered copy of the stored word is updated in place, so no buffer ever holds dirty data. Each buffer has eight fully associative entries, each of which can hold one block. Replacement picks the least recently used entry.

Addresses are word addresses. The low two bits select the word within a block, and the upper bits form the block number that is used as the tag.

Top module: `l0_unpack_unit`

## Requirements
- R1: After reset, rsp_valid, rd_valid, pf_valid and wt_valid are 0, and every buffer is empty, so the first load of any address misses.
- R2: A linear fill (fill_ilv=0) writes all four words of fill_data into the buffer of fill_cluster. Word i occupies bits 32i+31..32i. A load from that cluster issued in the cycle after the fill hits and returns the word. The other clusters' buffers are not changed.
- R3: A scatter fill (fill_ilv=1) writes word i only into cluster i's buffer, whatever fill_cluster is. A load issued in the cycle right after the fill still misses, and a load issued two cycles after it hits. fill_valid must be 0 in the cycle after a scatter fill.
- R4: A load with req_bypass=1 does no lookup and does not change the replacement order. One cycle later it gives rsp_hit=0, rsp_data=0, rd_valid=1 and rd_alloc=0.
- R5: One cycle after a load, rsp_valid=1. rsp_hit and rsp_data report the lookup result in req_cluster's buffer (rsp_data is 0 on a miss). On a miss, rd_valid=1 with rd_blk=req_addr[15:2], rd_cluster=req_cluster, rd_ilv=req_ilv and rd_alloc=1. On a hit, rd_valid=0.
- R6: One cycle after a non-bypass load with req_pf_next=1, pf_valid=1 and pf_blk is the load's block plus 1. With only req_pf_prev=1, pf_blk is the block minus 1. Both wrap modulo 2^14, and next wins when both hints are set. pf_cluster and pf_ilv copy the request.
- R7: One cycle after a store, wt_valid=1 with wt_addr=req_addr and wt_data=req_wdata. A store produces no rsp_valid.
- R8: A store overwrites the addressed word in every cluster's buffer that holds it, including when req_bypass is set. A store never allocates an entry.
- R9: Each buffer has 8 entries. A fill goes to an empty entry first. When the buffer is full, a fill replaces the entry that has gone longest without a fill or a load hit.
- R10: A fill of a block that is already present in the target buffer merges its words into that entry. The new words overwrite the old ones and no second entry is used.
- R11: If a store and a fill write the same word of a buffer in the same cycle, the store data is the value kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Memory access present |
| req_store | input | 1 | 1 = store, 0 = load |
| req_cluster | input | 2 | Issuing cluster |
| req_addr | input | 16 | Word address |
| req_wdata | input | 32 | Store data |
| req_bypass | input | 1 | Hint: skip the buffers |
| req_ilv | input | 1 | Hint: refill in scatter mode |
| req_pf_next | input | 1 | Hint: prefetch the following block |
| req_pf_prev | input | 1 | Hint: prefetch the preceding block |
| fill_valid | input | 1 | Block returning from first level |
| fill_cluster | input | 2 | Target cluster for a linear fill |
| fill_ilv | input | 1 | 1 = scatter fill, 0 = linear fill |
| fill_blk | input | 14 | Block number of the fill |
| fill_data | input | 128 | Four words, word i at bits 32i+31..32i |
| rsp_valid | output | 1 | Load answer present |
| rsp_hit | output | 1 | Load hit in buffer |
| rsp_data | output | 32 | Loaded word on hit, else 0 |
| rd_valid | output | 1 | Read request to first level |
| rd_blk | output | 14 | Block to read |
| rd_cluster | output | 2 | Requesting cluster |
| rd_ilv | output | 1 | Fill mode for the returned block |
| rd_alloc | output | 1 | Returned block should be buffered |
| pf_valid | output | 1 | Prefetch request |
| pf_blk | output | 14 | Block to prefetch |
| pf_cluster | output | 2 | Requesting cluster |
| pf_ilv | output | 1 | Fill mode for the prefetched block |
| wt_valid | output | 1 | Write-through to first level |
| wt_addr | output | 16 | Word address written |
| wt_data | output | 32 | Word written |

## Verification
Load answers, read requests, prefetch requests and write-throughs all appear on the first rising edge after the request is sampled. The bench therefore reads them 2 ns after that edge, before it drives the next request. Buffer contents change at the same edge for a linear fill and one edge later for a scatter fill, so a probe load issued in the cycle after a scatter fill must miss and one issued a cycle later must hit. The bench's model applies buffer changes in the same order the hardware does: the load's replacement refresh first, then the fill, then the store.

// File: rtl/l0u_pkg.sv
package l0u_pkg;
   typedef enum logic {
      MAP_LINEAR  = 1'b0,
      MAP_SCATTER = 1'b1
   } map_e;
endpackage

// File: rtl/l0u_unpack.sv
module l0u_unpack
   import l0u_pkg::*;
#(
   parameter int NUM_CL = 4,
   parameter int WORD_W = 32,
   parameter int TAG_W  = 14
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         fill_valid,
   input  logic [$clog2(NUM_CL)-1:0]    fill_cluster,
   input  map_e                         fill_map,
   input  logic [TAG_W-1:0]             fill_blk,
   input  logic [NUM_CL*WORD_W-1:0]     fill_data,
   output logic [NUM_CL-1:0]            wr_en,
   output logic [NUM_CL-1:0][NUM_CL-1:0] wr_mask,
   output logic [TAG_W-1:0]             wr_tag,
   output logic [NUM_CL*WORD_W-1:0]     wr_data,
   output logic                         busy
);
   localparam int CL_W = $clog2(NUM_CL);

   logic                     sc_v;
   logic [TAG_W-1:0]         sc_tag;
   logic [NUM_CL*WORD_W-1:0] sc_data;
   logic                     lin_go;

   assign lin_go = fill_valid && (fill_map == MAP_LINEAR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sc_v    <= 1'b0;
         sc_tag  <= '0;
         sc_data <= '0;
      end else begin
         sc_v <= fill_valid && (fill_map == MAP_SCATTER);
         if (fill_valid) begin
            sc_tag  <= fill_blk;
            sc_data <= fill_data;
         end
      end
   end

   for (genvar c = 0; c < NUM_CL; c++) begin : g_route
      always_comb begin
         if (sc_v) begin
            wr_en[c]   = 1'b1;
            wr_mask[c] = NUM_CL'(1) << c;
         end else begin
            wr_en[c]   = lin_go && (fill_cluster == CL_W'(c));
            wr_mask[c] = '1;
         end
      end
   end

   assign wr_tag  = sc_v ? sc_tag  : fill_blk;
   assign wr_data = sc_v ? sc_data : fill_data;
   assign busy    = sc_v;

   // R3: no new fill in the cycle the scattered block is being written
   p_fill_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid |-> !busy);
   // R3: a scattered block reaches every cluster on the following edge
   p_scatter_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_valid && fill_map == MAP_SCATTER) |=> (&wr_en) && (wr_tag == $past(fill_blk)));
endmodule

// File: rtl/l0u_bank.sv
module l0u_bank #(
   parameter int ENTRIES = 8,
   parameter int NW      = 4,
   parameter int WORD_W  = 32,
   parameter int TAG_W   = 14
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   fill_en,
   input  logic [TAG_W-1:0]       fill_tag,
   input  logic [NW-1:0]          fill_mask,
   input  logic [NW*WORD_W-1:0]   fill_data,
   input  logic                   st_en,
   input  logic [TAG_W-1:0]       st_tag,
   input  logic [$clog2(NW)-1:0]  st_word,
   input  logic [WORD_W-1:0]      st_data,
   input  logic                   lk_en,
   input  logic [TAG_W-1:0]       lk_tag,
   input  logic [$clog2(NW)-1:0]  lk_word,
   output logic                   lk_hit,
   output logic [WORD_W-1:0]      lk_data
);
   localparam int IDX_W    = $clog2(ENTRIES);
   localparam int BLK_BITS = NW * WORD_W;

   logic [TAG_W-1:0]    tag_q [ENTRIES];
   logic [NW-1:0]       msk_q [ENTRIES];
   logic [BLK_BITS-1:0] dat_q [ENTRIES];
   logic [IDX_W-1:0]    age_q [ENTRIES];

   logic [TAG_W-1:0]    tag_n [ENTRIES];
   logic [NW-1:0]       msk_n [ENTRIES];
   logic [BLK_BITS-1:0] dat_n [ENTRIES];
   logic [IDX_W-1:0]    age_l [ENTRIES];
   logic [IDX_W-1:0]    age_n [ENTRIES];

   logic [ENTRIES-1:0]  lk_vec, fm_vec;
   logic [IDX_W-1:0]    lk_idx, fm_idx, vic_idx, fill_idx;
   logic                fm_hit, free_found;

   // lookup and fill-tag match
   always_comb begin
      lk_idx = '0;
      fm_idx = '0;
      for (int e = 0; e < ENTRIES; e++) begin
         lk_vec[e] = lk_en && msk_q[e][lk_word] && (tag_q[e] == lk_tag);
         fm_vec[e] = (|msk_q[e]) && (tag_q[e] == fill_tag);
         if (lk_vec[e]) lk_idx = IDX_W'(e);
         if (fm_vec[e]) fm_idx = IDX_W'(e);
      end
      lk_hit  = |lk_vec;
      lk_data = lk_hit ? dat_q[lk_idx][lk_word*WORD_W +: WORD_W] : '0;
      fm_hit  = |fm_vec;
   end

   // recency: load hit refreshes first, victim chosen after that
   always_comb begin
      for (int e = 0; e < ENTRIES; e++) age_l[e] = age_q[e];
      if (lk_hit) begin
         for (int e = 0; e < ENTRIES; e++)
            if (age_q[e] < age_q[lk_idx]) age_l[e] = age_q[e] + 1'b1;
         age_l[lk_idx] = '0;
      end
      vic_idx    = '0;
      free_found = 1'b0;
      for (int e = ENTRIES - 1; e >= 0; e--)
         if (age_l[e] == IDX_W'(ENTRIES - 1)) vic_idx = IDX_W'(e);
      for (int e = 0; e < ENTRIES; e++)
         if (!free_found && msk_q[e] == '0) begin
            vic_idx    = IDX_W'(e);
            free_found = 1'b1;
         end
      fill_idx = fm_hit ? fm_idx : vic_idx;
      for (int e = 0; e < ENTRIES; e++) age_n[e] = age_l[e];
      if (fill_en) begin
         for (int e = 0; e < ENTRIES; e++)
            if (age_l[e] < age_l[fill_idx]) age_n[e] = age_l[e] + 1'b1;
         age_n[fill_idx] = '0;
      end
   end

   // contents: fill first, then store on top
   always_comb begin
      for (int e = 0; e < ENTRIES; e++) begin
         tag_n[e] = tag_q[e];
         msk_n[e] = msk_q[e];
         dat_n[e] = dat_q[e];
      end
      if (fill_en) begin
         tag_n[fill_idx] = fill_tag;
         msk_n[fill_idx] = fm_hit ? (msk_q[fill_idx] | fill_mask) : fill_mask;
         for (int w = 0; w < NW; w++)
            if (fill_mask[w])
               dat_n[fill_idx][w*WORD_W +: WORD_W] = fill_data[w*WORD_W +: WORD_W];
      end
      if (st_en) begin
         for (int e = 0; e < ENTRIES; e++)
            if (msk_n[e][st_word] && tag_n[e] == st_tag)
               dat_n[e][st_word*WORD_W +: WORD_W] = st_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int e = 0; e < ENTRIES; e++) begin
            tag_q[e] <= '0;
            msk_q[e] <= '0;
            dat_q[e] <= '0;
            age_q[e] <= IDX_W'(e);
         end
      end else begin
         for (int e = 0; e < ENTRIES; e++) begin
            tag_q[e] <= tag_n[e];
            msk_q[e] <= msk_n[e];
            dat_q[e] <= dat_n[e];
            age_q[e] <= age_n[e];
         end
      end
   end

   logic [ENTRIES-1:0] age_seen;
   always_comb begin
      age_seen = '0;
      for (int e = 0; e < ENTRIES; e++) age_seen[age_q[e]] = 1'b1;
   end

   // R9: recency ranks always form a permutation
   p_lru_perm_r9: assert property (@(posedge clk) disable iff (!rst_n) &age_seen);
   // R10: a block never occupies two entries of one buffer
   p_tag_unique_r10: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(fm_vec));
   // R5: at most one entry answers a lookup
   p_lookup_unique_r5: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(lk_vec));
endmodule

// File: rtl/l0_unpack_unit.sv
module l0_unpack_unit
   import l0u_pkg::*;
#(
   parameter int NUM_CL  = 4,
   parameter int WORD_W  = 32,
   parameter int ADDR_W  = 16,
   parameter int ENTRIES = 8
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             req_valid,
   input  logic                             req_store,
   input  logic [$clog2(NUM_CL)-1:0]        req_cluster,
   input  logic [ADDR_W-1:0]                req_addr,
   input  logic [WORD_W-1:0]                req_wdata,
   input  logic                             req_bypass,
   input  logic                             req_ilv,
   input  logic                             req_pf_next,
   input  logic                             req_pf_prev,
   input  logic                             fill_valid,
   input  logic [$clog2(NUM_CL)-1:0]        fill_cluster,
   input  logic                             fill_ilv,
   input  logic [ADDR_W-$clog2(NUM_CL)-1:0] fill_blk,
   input  logic [NUM_CL*WORD_W-1:0]         fill_data,
   output logic                             rsp_valid,
   output logic                             rsp_hit,
   output logic [WORD_W-1:0]                rsp_data,
   output logic                             rd_valid,
   output logic [ADDR_W-$clog2(NUM_CL)-1:0] rd_blk,
   output logic [$clog2(NUM_CL)-1:0]        rd_cluster,
   output logic                             rd_ilv,
   output logic                             rd_alloc,
   output logic                             pf_valid,
   output logic [ADDR_W-$clog2(NUM_CL)-1:0] pf_blk,
   output logic [$clog2(NUM_CL)-1:0]        pf_cluster,
   output logic                             pf_ilv,
   output logic                             wt_valid,
   output logic [ADDR_W-1:0]                wt_addr,
   output logic [WORD_W-1:0]                wt_data
);
   localparam int NW       = NUM_CL;
   localparam int WI_W     = $clog2(NW);
   localparam int CL_W     = $clog2(NUM_CL);
   localparam int BLK_W    = ADDR_W - WI_W;
   localparam int BLK_BITS = NW * WORD_W;

   if (NUM_CL < 2 || (NUM_CL & (NUM_CL - 1)) != 0) begin : g_bad_cl
      $error("NUM_CL must be a power of two and at least 2");
   end
   if (ENTRIES < 2) begin : g_bad_ent
      $error("ENTRIES must be at least 2");
   end
   if (ADDR_W <= WI_W) begin : g_bad_addr
      $error("ADDR_W too small for the word index");
   end

   logic [BLK_W-1:0] req_blk;
   logic [WI_W-1:0]  req_word;
   logic             is_load, is_store, do_lookup, sel_hit;

   assign req_blk   = req_addr[ADDR_W-1:WI_W];
   assign req_word  = req_addr[WI_W-1:0];
   assign is_load   = req_valid && !req_store;
   assign is_store  = req_valid && req_store;
   assign do_lookup = is_load && !req_bypass;

   logic [NUM_CL-1:0]           wr_en;
   logic [NUM_CL-1:0][NW-1:0]   wr_mask;
   logic [BLK_W-1:0]            wr_tag;
   logic [BLK_BITS-1:0]         wr_data;
   logic                        unpack_busy;

   l0u_unpack #(.NUM_CL(NUM_CL), .WORD_W(WORD_W), .TAG_W(BLK_W)) u_unpack (
      .clk          (clk),
      .rst_n        (rst_n),
      .fill_valid   (fill_valid),
      .fill_cluster (fill_cluster),
      .fill_map     (map_e'(fill_ilv)),
      .fill_blk     (fill_blk),
      .fill_data    (fill_data),
      .wr_en        (wr_en),
      .wr_mask      (wr_mask),
      .wr_tag       (wr_tag),
      .wr_data      (wr_data),
      .busy         (unpack_busy)
   );

   logic [NUM_CL-1:0] bk_hit;
   logic [WORD_W-1:0] bk_data [NUM_CL];

   for (genvar c = 0; c < NUM_CL; c++) begin : g_bank
      l0u_bank #(.ENTRIES(ENTRIES), .NW(NW), .WORD_W(WORD_W), .TAG_W(BLK_W)) u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .fill_en   (wr_en[c]),
         .fill_tag  (wr_tag),
         .fill_mask (wr_mask[c]),
         .fill_data (wr_data),
         .st_en     (is_store),
         .st_tag    (req_blk),
         .st_word   (req_word),
         .st_data   (req_wdata),
         .lk_en     (do_lookup && (req_cluster == CL_W'(c))),
         .lk_tag    (req_blk),
         .lk_word   (req_word),
         .lk_hit    (bk_hit[c]),
         .lk_data   (bk_data[c])
      );
   end

   assign sel_hit = do_lookup && bk_hit[req_cluster];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_hit    <= 1'b0;
         rsp_data   <= '0;
         rd_valid   <= 1'b0;
         rd_blk     <= '0;
         rd_cluster <= '0;
         rd_ilv     <= 1'b0;
         rd_alloc   <= 1'b0;
         pf_valid   <= 1'b0;
         pf_blk     <= '0;
         pf_cluster <= '0;
         pf_ilv     <= 1'b0;
         wt_valid   <= 1'b0;
         wt_addr    <= '0;
         wt_data    <= '0;
      end else begin
         rsp_valid  <= is_load;
         rsp_hit    <= sel_hit;
         rsp_data   <= sel_hit ? bk_data[req_cluster] : '0;
         rd_valid   <= is_load && !sel_hit;
         rd_blk     <= req_blk;
         rd_cluster <= req_cluster;
         rd_ilv     <= req_ilv;
         rd_alloc   <= !req_bypass;
         pf_valid   <= do_lookup && (req_pf_next || req_pf_prev);
         pf_blk     <= req_pf_next ? req_blk + BLK_W'(1) : req_blk - BLK_W'(1);
         pf_cluster <= req_cluster;
         pf_ilv     <= req_ilv;
         wt_valid   <= is_store;
         wt_addr    <= req_addr;
         wt_data    <= req_wdata;
      end
   end

   // R7: every store is written through on the next edge
   p_store_through_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_store) |=> wt_valid && wt_data == $past(req_wdata)
                                    && wt_addr == $past(req_addr) && !rsp_valid);
   // R4: bypassed loads always go to the first level without allocation
   p_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_store && req_bypass) |=> rd_valid && !rd_alloc && !rsp_hit);
   // R5: an answered load either hit or fetched, never both
   p_hit_or_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_hit != rd_valid));
   // R6: next-block prefetch address
   p_pf_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_store && !req_bypass && req_pf_next)
         |=> pf_valid && pf_blk == $past(req_blk) + BLK_W'(1));
endmodule

// File: tb/l0_unpack_unit_test.sv
module l0_unpack_unit_test;
   localparam int CLK_NS = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid, req_store, req_bypass, req_ilv, req_pf_next, req_pf_prev;
   logic [1:0]   req_cluster;
   logic [15:0]  req_addr;
   logic [31:0]  req_wdata;
   logic         fill_valid, fill_ilv;
   logic [1:0]   fill_cluster;
   logic [13:0]  fill_blk;
   logic [127:0] fill_data;
   logic         rsp_valid, rsp_hit, rd_valid, rd_ilv, rd_alloc, pf_valid, pf_ilv, wt_valid;
   logic [31:0]  rsp_data, wt_data;
   logic [13:0]  rd_blk, pf_blk;
   logic [1:0]   rd_cluster, pf_cluster;
   logic [15:0]  wt_addr;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #(CLK_NS/2) clk = ~clk;

   l0_unpack_unit uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_store(req_store), .req_cluster(req_cluster),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_bypass(req_bypass),
      .req_ilv(req_ilv), .req_pf_next(req_pf_next), .req_pf_prev(req_pf_prev),
      .fill_valid(fill_valid), .fill_cluster(fill_cluster), .fill_ilv(fill_ilv),
      .fill_blk(fill_blk), .fill_data(fill_data),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
      .rd_valid(rd_valid), .rd_blk(rd_blk), .rd_cluster(rd_cluster),
      .rd_ilv(rd_ilv), .rd_alloc(rd_alloc),
      .pf_valid(pf_valid), .pf_blk(pf_blk), .pf_cluster(pf_cluster), .pf_ilv(pf_ilv),
      .wt_valid(wt_valid), .wt_addr(wt_addr), .wt_data(wt_data)
   );

   // reference model of the four buffers
   int          m_tag [4][8];
   logic [3:0]  m_msk [4][8];
   logic [31:0] m_dat [4][8][4];
   int          m_age [4][8];
   bit           p_v;
   int           p_blk;
   logic [127:0] p_dat;

   task automatic chk(input string tg, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h", tg, what, act, exp);
      end
   endtask

   function automatic logic [127:0] pat(input int blk, input int salt);
      logic [127:0] v;
      for (int w = 0; w < 4; w++)
         v[w*32 +: 32] = 32'hD000_0000 | (32'(salt) << 20) | (32'(blk) << 4) | 32'(w);
      return v;
   endfunction

   function automatic int m_find(input int c, input int blk);
      for (int e = 0; e < 8; e++)
         if (m_msk[c][e] != 4'b0 && m_tag[c][e] == blk) return e;
      return -1;
   endfunction

   task automatic touch(input int c, input int k);
      int a = m_age[c][k];
      for (int e = 0; e < 8; e++)
         if (m_age[c][e] < a) m_age[c][e]++;
      m_age[c][k] = 0;
   endtask

   task automatic model_fill(input int c, input int blk, input logic [3:0] mask,
                             input logic [127:0] d);
      int k = m_find(c, blk);
      if (k < 0) begin
         for (int e = 0; e < 8; e++)
            if (k < 0 && m_msk[c][e] == 4'b0) k = e;
         if (k < 0)
            for (int e = 0; e < 8; e++)
               if (m_age[c][e] == 7) k = e;
         m_tag[c][k] = blk;
         m_msk[c][k] = mask;
      end else begin
         m_msk[c][k] = m_msk[c][k] | mask;
      end
      for (int w = 0; w < 4; w++)
         if (mask[w]) m_dat[c][k][w] = d[w*32 +: 32];
      touch(c, k);
   endtask

   task automatic model_store(input int blk, input int w, input logic [31:0] d);
      for (int c = 0; c < 4; c++)
         for (int e = 0; e < 8; e++)
            if (m_msk[c][e][w] && m_tag[c][e] == blk) m_dat[c][e][w] = d;
   endtask

   task automatic idle();
      req_valid = 0; req_store = 0; req_cluster = 0; req_addr = 0; req_wdata = 0;
      req_bypass = 0; req_ilv = 0; req_pf_next = 0; req_pf_prev = 0;
      fill_valid = 0; fill_cluster = 0; fill_ilv = 0; fill_blk = 0; fill_data = 0;
   endtask

   // one clock with the current inputs; model updated in hardware order
   task automatic cyc(input string tg);
      bit ld = req_valid && !req_store;
      bit st = req_valid && req_store;
      int c = int'(req_cluster);
      int blk = int'(req_addr[15:2]);
      int w = int'(req_addr[1:0]);
      bit eh = 0;
      logic [31:0] ed = 0;
      int k = -1;
      bit epf;
      logic [13:0] epb;
      if (ld && !req_bypass) begin
         k = m_find(c, blk);
         if (k >= 0 && m_msk[c][k][w]) begin
            eh = 1; ed = m_dat[c][k][w];
         end else k = -1;
      end
      epf = ld && !req_bypass && (req_pf_next || req_pf_prev);
      epb = req_pf_next ? req_addr[15:2] + 14'd1 : req_addr[15:2] - 14'd1;
      if (k >= 0) touch(c, k);
      if (p_v) begin
         for (int cc = 0; cc < 4; cc++) model_fill(cc, p_blk, 4'b1 << cc, p_dat);
      end else if (fill_valid && !fill_ilv) begin
         model_fill(int'(fill_cluster), int'(fill_blk), 4'hF, fill_data);
      end
      if (st) model_store(blk, w, req_wdata);
      p_v = fill_valid && fill_ilv;
      p_blk = int'(fill_blk);
      p_dat = fill_data;
      begin
         bit byp = req_bypass;
         logic [1:0] rc = req_cluster;
         logic rilv = req_ilv;
         logic [15:0] ra = req_addr;
         logic [31:0] rw = req_wdata;
         @(posedge clk);
         #2;
         chk(tg, "rsp_valid", rsp_valid, ld);
         if (ld) begin
            chk(tg, "rsp_hit", rsp_hit, eh);
            chk(tg, "rsp_data", rsp_data, ed);
            chk(byp ? "R4" : "R5", "rd_valid", rd_valid, byp || !eh);
            if (byp || !eh) begin
               chk(byp ? "R4" : "R5", "rd_alloc", rd_alloc, !byp);
               chk("R5", "rd_blk", rd_blk, ra[15:2]);
               chk("R5", "rd_cluster", rd_cluster, rc);
               chk("R5", "rd_ilv", rd_ilv, rilv);
            end
         end else begin
            chk("R5", "rd_valid idle", rd_valid, 1'b0);
         end
         chk("R6", "pf_valid", pf_valid, epf);
         if (epf) begin
            chk("R6", "pf_blk", pf_blk, epb);
            chk("R6", "pf_cluster", pf_cluster, rc);
            chk("R6", "pf_ilv", pf_ilv, rilv);
         end
         chk("R7", "wt_valid", wt_valid, st);
         if (st) begin
            chk("R7", "wt_addr", wt_addr, ra);
            chk("R7", "wt_data", wt_data, rw);
         end
      end
      idle();
   endtask

   task automatic do_fill(input int c, input int blk, input bit ilv,
                          input logic [127:0] d, input string tg);
      fill_valid = 1; fill_cluster = 2'(c); fill_ilv = ilv; fill_blk = 14'(blk); fill_data = d;
      cyc(tg);
   endtask

   task automatic do_load(input int c, input int blk, input int w, input bit byp,
                          input bit eh, input logic [31:0] ed, input string tg);
      req_valid = 1; req_cluster = 2'(c); req_addr = {14'(blk), 2'(w)}; req_bypass = byp;
      cyc(tg);
      chk(tg, "directed hit", rsp_hit, eh);
      chk(tg, "directed data", rsp_data, ed);
   endtask

   task automatic do_store(input int blk, input int w, input logic [31:0] d, input bit byp);
      req_valid = 1; req_store = 1; req_addr = {14'(blk), 2'(w)}; req_wdata = d;
      req_bypass = byp;
      cyc("R7");
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
   endtask

   initial begin
      #(CLK_NS * 150000);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog: actual running expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [127:0] d;
      idle();
      p_v = 0;
      for (int c = 0; c < 4; c++)
         for (int e = 0; e < 8; e++) begin
            m_msk[c][e] = 0; m_tag[c][e] = 0; m_age[c][e] = e;
            for (int w = 0; w < 4; w++) m_dat[c][e][w] = 0;
         end
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      #2;
      chk("R1", "rsp_valid in reset", rsp_valid, 1'b0);
      chk("R1", "rd_valid in reset", rd_valid, 1'b0);
      chk("R1", "pf_valid in reset", pf_valid, 1'b0);
      chk("R1", "wt_valid in reset", wt_valid, 1'b0);
      rst_n = 1;
      @(posedge clk); #2;
      do_load(0, 5, 1, 0, 0, 0, "R1");

      // R2 linear fill
      do_fill(1, 5, 0, pat(5, 1), "R2");
      do_load(1, 5, 2, 0, 1, pat(5, 1)[95:64], "R2");
      do_load(0, 5, 2, 0, 0, 0, "R2");

      // R3 scatter fill: visible after two cycles only
      do_fill(0, 9, 1, pat(9, 2), "R3");
      do_load(2, 9, 2, 0, 0, 0, "R3");
      do_load(2, 9, 2, 0, 1, pat(9, 2)[95:64], "R3");
      do_load(3, 9, 2, 0, 0, 0, "R3");
      do_load(3, 9, 3, 0, 1, pat(9, 2)[127:96], "R3");

      // R4 bypass
      do_load(1, 5, 2, 1, 0, 0, "R4");

      // R6 prefetch hints
      req_valid = 1; req_cluster = 1; req_addr = {14'd5, 2'd0}; req_pf_next = 1; req_ilv = 1;
      cyc("R6");
      chk("R6", "next block", pf_blk, 14'd6);
      req_valid = 1; req_cluster = 2; req_addr = {14'd5, 2'd0}; req_pf_prev = 1;
      cyc("R6");
      chk("R6", "previous block", pf_blk, 14'd4);
      req_valid = 1; req_addr = {14'd5, 2'd0}; req_pf_prev = 1; req_pf_next = 1;
      cyc("R6");
      chk("R6", "next wins", pf_blk, 14'd6);
      req_valid = 1; req_addr = {14'd0, 2'd0}; req_pf_prev = 1;
      cyc("R6");
      chk("R6", "wrap below zero", pf_blk, 14'h3FFF);
      req_valid = 1; req_addr = {14'd0, 2'd0}; req_pf_prev = 1; req_bypass = 1;
      cyc("R6");
      chk("R6", "bypass no prefetch", pf_valid, 1'b0);

      // R8 store updates every copy, bypass too, never allocates
      do_fill(0, 9, 0, pat(9, 3), "R2");
      do_store(9, 2, 32'h1111_2222, 0);
      do_load(0, 9, 2, 0, 1, 32'h1111_2222, "R8");
      do_load(2, 9, 2, 0, 1, 32'h1111_2222, "R8");
      do_store(9, 3, 32'h3333_4444, 1);
      do_load(3, 9, 3, 0, 1, 32'h3333_4444, "R8");
      do_store(20, 0, 32'h5555_6666, 0);
      do_load(0, 20, 0, 0, 0, 0, "R8");

      // R10 merge: scatter then linear of the same block in cluster 1
      do_fill(2, 12, 1, pat(12, 4), "R10");
      do_load(1, 12, 0, 0, 0, 0, "R10");
      do_load(1, 12, 1, 0, 1, pat(12, 4)[63:32], "R10");
      do_fill(1, 12, 0, pat(12, 5), "R10");
      do_load(1, 12, 0, 0, 1, pat(12, 5)[31:0], "R10");
      do_load(1, 12, 1, 0, 1, pat(12, 5)[63:32], "R10");

      // R11 store and fill to the same word in one cycle
      fill_valid = 1; fill_cluster = 2; fill_blk = 30; fill_data = pat(30, 6);
      req_valid = 1; req_store = 1; req_addr = {14'd30, 2'd1}; req_wdata = 32'hABCD_0123;
      cyc("R11");
      do_load(2, 30, 1, 0, 1, 32'hABCD_0123, "R11");
      do_load(2, 30, 0, 0, 1, pat(30, 6)[31:0], "R11");

      // R9 replacement in cluster 3 (holds blocks 9 and 12 already)
      for (int b = 40; b < 48; b++) do_fill(3, b, 0, pat(b, 7), "R9");
      do_load(3, 9, 3, 0, 0, 0, "R9");
      do_load(3, 12, 3, 0, 0, 0, "R9");
      do_load(3, 40, 1, 0, 1, pat(40, 7)[63:32], "R9");
      do_fill(3, 48, 0, pat(48, 7), "R9");
      do_load(3, 41, 0, 0, 0, 0, "R9");
      do_load(3, 40, 0, 0, 1, pat(40, 7)[31:0], "R9");
      do_load(3, 48, 2, 0, 1, pat(48, 7)[95:64], "R9");
      do_load(3, 42, 3, 0, 1, pat(42, 7)[127:96], "R9");

      // constrained random mix against the model
      for (int i = 0; i < 4000; i++) begin
         int r = int'($urandom % 10);
         if (r < 5) begin
            req_valid = 1; req_cluster = 2'($urandom);
            req_addr = {14'($urandom % 24), 2'($urandom)};
            req_bypass = ($urandom % 8) == 0; req_ilv = 1'($urandom);
            req_pf_next = ($urandom % 4) == 0; req_pf_prev = ($urandom % 4) == 0;
         end else if (r < 7) begin
            req_valid = 1; req_store = 1; req_cluster = 2'($urandom);
            req_addr = {14'($urandom % 24), 2'($urandom)};
            req_wdata = $urandom; req_bypass = 1'($urandom);
         end
         if (!p_v && ($urandom % 3) == 0) begin
            d = {$urandom, $urandom, $urandom, $urandom};
            fill_valid = 1; fill_cluster = 2'($urandom); fill_ilv = 1'($urandom);
            fill_blk = 14'($urandom % 24); fill_data = d;
         end
         cyc("R5");
      end

      done = 1'b1;
      summary();
      $finish;
   end
endmodule